// File: doc/BRIEF.md
# Four-Channel Pulse Totalizer

This block keeps a single running total of the pulses arriving on four independent square-wave inputs. The inputs are asynchronous to each other and to the system clock, run from a few kilohertz to a few tens of kilohertz, and any of them may sit idle at low level for long stretches. Everything runs on one fast system clock, which must be fast enough that every high and low phase of every input spans several clock cycles.

Each input is brought into the clock domain through a two-flop synchronizer and then a history register. A pulse is recognised when the synchronized level goes from 0 to 1. In every cycle, the number of channels that showed a new rising edge (0 to 4) is added to the total. No gate-merged clock is built, so edges that land in the same cycle on different channels are all counted. Optional per-channel counters, selected by a parameter, give the same result split by channel. A synchronous clear strobe zeroes the total and all channel counters.

Top module: `pulse_totalizer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `total`, every channel count and `incr` are zero after that edge.
- R2: Each 0-to-1 transition of a channel input adds exactly one to `total`, however long the input then stays high.
- R3: Rising edges on several channels that are detected in the same cycle are all counted; `incr` reaches 4 when all channels rise together.
- R4: A channel input that stays low adds nothing to `total` and leaves its own channel count unchanged.
- R5: A rising input first sampled high at clock edge k is added to `total` at clock edge k+2.
- R6: `incr` equals the number of channels with a detected rising edge in the current cycle (0 to 4), and is 0 in any cycle where `clr` is high.
- R7: With channel counting enabled, the sum of the four 24-bit channel counts, taken modulo 2^24, equals the low 24 bits of `total` in every cycle; channel c occupies bits [24c+23:24c] of `chan_count`.
- R8: A clock edge with `clr` high sets `total` and every channel count to zero, and an edge detected in that cycle is not counted later.
- R9: An input that is already high when reset is released adds nothing until it goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of total and channel counts |
| pulse_in | input | 4 | Asynchronous pulse inputs, one bit per channel |
| total | output | 32 | Running total of pulses on all channels, wraps modulo 2^32 |
| chan_count | output | 96 | Per-channel counts, 24 bits each, channel 0 in the low bits |
| incr | output | 3 | Number of channel edges being added this cycle |

## Verification
The bench aims at the cases that separate a true totalizer from a merged-clock counter: all four channels rising in the same cycle (a design that ORs the edges would add one instead of four) and long high phases (an edge detector that is level-sensitive would count on every cycle). It holds inputs high across reset release, where a pipeline that starts at zero would report a false edge, and it asserts clear in exactly the cycle an edge is pending, where a design that lets the edge through would show a count of one after the clear. Long runs with an idle channel and uneven square waves check every output against a behavioural model on each clock, which catches latency and per-channel bookkeeping errors.

// File: rtl/pulse_tot_pkg.sv
// Package: shared sizing constants for the pulse totalizer.
// Assumes: consumers derive all widths from these values.
package pulse_tot_pkg;
    localparam int unsigned NUM_CH      = 4;
    localparam int unsigned TOT_W       = 32;
    localparam int unsigned CH_W        = 24;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pte_chan_front.sv
// Module: pte_chan_front
// Brings one asynchronous pulse input into the clock domain and flags
// its rising edges for exactly one cycle.
// Assumes: the input's high and low phases each last several clocks;
// STAGES >= 2. The edge flag is masked until the synchronizer and the
// history register hold real samples, so a level that is already high
// at reset release is not taken as an edge.
module pte_chan_front #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              hist_q;
    logic [STAGES:0]   warm_q;

    // Shift the raw level through the synchronizer and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw_in};
            hist_q <= sync_q[STAGES-1];
        end
    end

    // Track how many stages hold a real sample since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else begin
            warm_q <= {warm_q[STAGES-1:0], 1'b1};
        end
    end

    // Report a rise only once all stages carry sampled data.
    always_comb begin
        rise = warm_q[STAGES] & sync_q[STAGES-1] & ~hist_q;
    end
endmodule

// File: rtl/pte_popcount.sv
// Module: pte_popcount
// Counts the set bits of a small vector.
// Assumes: OUT_W is wide enough to hold N.
module pte_popcount #(
    parameter int unsigned N     = 4,
    parameter int unsigned OUT_W = 3
) (
    input  logic [N-1:0]     bits_in,
    output logic [OUT_W-1:0] ones
);
    // Sum the input bits one by one.
    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + OUT_W'(bits_in[i]);
        end
    end
endmodule

// File: rtl/pulse_totalizer.sv
// Module: pulse_totalizer (top)
// Totals rising edges seen on NUM_CH asynchronous pulse inputs. Each
// cycle the number of channels with a new edge is added to the total,
// so coincident edges are never merged. Optional per-channel counters
// split the same count by channel.
// Assumes: one system clock much faster than any input; synchronous
// active-low reset; clr has priority over counting and drops the edge
// detected in its own cycle.
module pulse_totalizer #(
    parameter int unsigned NUM_CH      = pulse_tot_pkg::NUM_CH,
    parameter int unsigned TOT_W       = pulse_tot_pkg::TOT_W,
    parameter int unsigned CH_W        = pulse_tot_pkg::CH_W,
    parameter int unsigned SYNC_STAGES = pulse_tot_pkg::SYNC_STAGES,
    parameter bit          EN_CH_CNT   = 1'b1,
    localparam int unsigned INC_W      = $clog2(NUM_CH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [NUM_CH-1:0]      pulse_in,
    output logic [TOT_W-1:0]       total,
    output logic [NUM_CH*CH_W-1:0] chan_count,
    output logic [INC_W-1:0]       incr
);
    logic [NUM_CH-1:0] rise_vec;
    logic [INC_W-1:0]  edge_sum;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            pte_chan_front #(.STAGES(SYNC_STAGES)) u_front (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_in (pulse_in[c]),
                .rise   (rise_vec[c])
            );

            if (EN_CH_CNT) begin : g_cnt
                logic [CH_W-1:0] cnt_q;
                // Count this channel's edges; clear and reset zero it.
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) begin
                        cnt_q <= '0;
                    end else if (rise_vec[c]) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                assign chan_count[c*CH_W +: CH_W] = cnt_q;
            end else begin : g_nocnt
                assign chan_count[c*CH_W +: CH_W] = '0;
            end
        end
    endgenerate

    pte_popcount #(.N(NUM_CH), .OUT_W(INC_W)) u_pop (
        .bits_in (rise_vec),
        .ones    (edge_sum)
    );

    // Present the increment, suppressed in a clear cycle.
    always_comb begin
        incr = clr ? '0 : edge_sum;
    end

    // Accumulate the per-cycle increment into the wrapping total.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            total <= '0;
        end else begin
            total <= total + {{(TOT_W-INC_W){1'b0}}, incr};
        end
    end
endmodule

// File: rtl/pulse_totalizer_chk.sv
// Module: pulse_totalizer_chk
// Property checker bound to pulse_totalizer; observes ports only.
// Assumes: reset is asserted from time zero.
module pulse_totalizer_chk #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned TOT_W     = 32,
    parameter int unsigned CH_W      = 24,
    parameter bit          EN_CH_CNT = 1'b1,
    parameter int unsigned INC_W     = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr,
    input logic [TOT_W-1:0]       total,
    input logic [NUM_CH*CH_W-1:0] chan_count,
    input logic [INC_W-1:0]       incr
);
    logic [CH_W-1:0] ch_sum;

    // Add up the channel counts modulo 2^CH_W.
    always_comb begin
        ch_sum = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            ch_sum = ch_sum + chan_count[i*CH_W +: CH_W];
        end
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (total == '0 && chan_count == '0));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total == '0 && chan_count == '0));

    a_r6_incr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (incr <= INC_W'(NUM_CH)) && (!clr || incr == '0));

    a_r5_total_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rst_n) |=> (total == $past(total) + TOT_W'($past(incr))));

    a_r7_channel_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (!EN_CH_CNT) || (ch_sum == total[CH_W-1:0]));
endmodule

bind pulse_totalizer pulse_totalizer_chk #(
    .NUM_CH    (NUM_CH),
    .TOT_W     (TOT_W),
    .CH_W      (CH_W),
    .EN_CH_CNT (EN_CH_CNT),
    .INC_W     (INC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .total      (total),
    .chan_count (chan_count),
    .incr       (incr)
);

// File: tb/pulse_totalizer_bench.sv
// Bench for pulse_totalizer: behavioural sample-history model compared
// on every clock, plus directed checks tagged by requirement.
module pulse_totalizer_bench;
    localparam int NC = 4;
    localparam int CW = 24;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              clr   = 1'b0;
    logic [NC-1:0]     pin   = '0;
    logic [31:0]       total;
    logic [NC*CW-1:0]  chan_count;
    logic [2:0]        incr;

    int vectors = 0;
    int miss    = 0;
    bit done    = 0;

    pulse_totalizer u_pulse_totalizer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .pulse_in   (pin),
        .total      (total),
        .chan_count (chan_count),
        .incr       (incr)
    );

    // Model state: recent input samples per channel, counts since reset.
    bit          hist[NC][$];
    int          n_seen = 0;
    logic [31:0] m_total = '0;
    logic [CW-1:0] m_ch[NC];
    int          m_incr = 0;

    function automatic bit vis(int c);
        int s = hist[c].size();
        if (n_seen < 3 || s < 3) return 0;
        return hist[c][s-2] && !hist[c][s-3];
    endfunction

    task automatic model_step(input logic [NC-1:0] p, input logic c, input logic r);
        int add = 0;
        if (!r) begin
            n_seen = 0;
            m_total = '0;
            for (int i = 0; i < NC; i++) begin
                hist[i].delete();
                m_ch[i] = '0;
            end
        end else begin
            for (int i = 0; i < NC; i++) begin
                if (vis(i)) begin
                    add++;
                    if (!c) m_ch[i] = m_ch[i] + 1'b1;
                end
            end
            if (c) begin
                m_total = '0;
                for (int i = 0; i < NC; i++) m_ch[i] = '0;
            end else begin
                m_total = m_total + 32'(add);
            end
            for (int i = 0; i < NC; i++) begin
                hist[i].push_back(p[i]);
                if (hist[i].size() > 4) void'(hist[i].pop_front());
            end
            n_seen++;
        end
        m_incr = 0;
        if (r && !c) begin
            for (int i = 0; i < NC; i++) if (vis(i)) m_incr++;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 total vs model", total, m_total);
        chk("R6 incr vs model", 32'(incr), 32'(m_incr));
        for (int i = 0; i < NC; i++)
            chk("R7 channel count vs model", 32'(chan_count[i*CW +: CW]), 32'(m_ch[i]));
    endtask

    task automatic cyc(input logic [NC-1:0] p, input logic c, input logic r);
        pin = p;
        clr = c;
        rst_n = r;
        @(posedge clk);
        model_step(p, c, r);
        @(negedge clk);
        compare_all();
    endtask

    // Free-running square waves; channels with zero half-period stay low.
    task automatic run_squares(input int cycles, input int hp0, input int hp1,
                               input int hp2, input int hp3);
        int hp[NC];
        int ph[NC];
        logic [NC-1:0] lv;
        hp[0] = hp0; hp[1] = hp1; hp[2] = hp2; hp[3] = hp3;
        lv = pin;
        for (int i = 0; i < NC; i++) ph[i] = $urandom_range(0, 5);
        for (int k = 0; k < cycles; k++) begin
            for (int i = 0; i < NC; i++) begin
                if (hp[i] == 0) begin
                    lv[i] = 1'b0;
                end else begin
                    ph[i]++;
                    if (ph[i] >= hp[i]) begin
                        ph[i] = 0;
                        lv[i] = ~lv[i];
                    end
                end
            end
            cyc(lv, 1'b0, 1'b1);
        end
    endtask

    function automatic logic [31:0] chan_sum();
        logic [CW-1:0] s = '0;
        for (int i = 0; i < NC; i++) s = s + chan_count[i*CW +: CW];
        return 32'(s);
    endfunction

    initial begin
        logic [CW-1:0] ch1_before;
        logic [31:0]   tot_before;

        // R1: reset with some inputs high
        for (int k = 0; k < 4; k++) cyc(4'b0101, 1'b0, 1'b0);
        chk("R1 total in reset", total, 32'd0);
        chk("R1 incr in reset", 32'(incr), 32'd0);
        chk("R1 channel counts in reset", chan_sum(), 32'd0);

        // R9: high at reset release is not a pulse
        for (int k = 0; k < 10; k++) cyc(4'b0101, 1'b0, 1'b1);
        chk("R9 no count for level high at release", total, 32'd0);
        for (int k = 0; k < 6; k++) cyc(4'b0000, 1'b0, 1'b1);
        chk("R9 falling edges add nothing", total, 32'd0);

        // R5: latency of a single rise on channel 0
        cyc(4'b0001, 1'b0, 1'b1);
        chk("R5 not counted after first sampling edge", total, 32'd0);
        cyc(4'b0001, 1'b0, 1'b1);
        chk("R6 incr shows one pending edge", 32'(incr), 32'd1);
        chk("R5 not counted after second edge", total, 32'd0);
        cyc(4'b0001, 1'b0, 1'b1);
        chk("R5 counted at k+2", total, 32'd1);

        // R2: long high phase counts once
        for (int k = 0; k < 8; k++) cyc(4'b0001, 1'b0, 1'b1);
        chk("R2 one count per pulse", total, 32'd1);
        for (int k = 0; k < 4; k++) cyc(4'b0000, 1'b0, 1'b1);

        // R3: all four rise together
        cyc(4'b1111, 1'b0, 1'b1);
        cyc(4'b1111, 1'b0, 1'b1);
        chk("R3 incr for four coincident edges", 32'(incr), 32'd4);
        cyc(4'b1111, 1'b0, 1'b1);
        chk("R3 total after coincident edges", total, 32'd5);
        for (int k = 0; k < 5; k++) cyc(4'b0000, 1'b0, 1'b1);

        // R8: clear in the cycle an edge is pending
        cyc(4'b0100, 1'b0, 1'b1);
        cyc(4'b0100, 1'b0, 1'b1);
        chk("R6 pending edge before clear", 32'(incr), 32'd1);
        cyc(4'b0100, 1'b1, 1'b1);
        chk("R6 incr zero while clear high", 32'(incr), 32'd0);
        for (int k = 0; k < 3; k++) cyc(4'b0100, 1'b0, 1'b1);
        chk("R8 total zero, pending edge dropped", total, 32'd0);
        chk("R8 channel 2 zero after clear", 32'(chan_count[2*CW +: CW]), 32'd0);
        for (int k = 0; k < 4; k++) cyc(4'b0000, 1'b0, 1'b1);

        // R4: channel 1 idle while others toggle
        ch1_before = chan_count[1*CW +: CW];
        tot_before = total;
        run_squares(3000, 5, 0, 7, 11);
        chk("R4 idle channel count unchanged", 32'(chan_count[1*CW +: CW]), 32'(ch1_before));
        vectors++;
        if (total == tot_before) begin
            miss++;
            $display("FAIL R4: actual %0d expected more than %0d", total, tot_before);
        end

        // Mixed rates, a mid-run clear and a mid-run reset
        run_squares(4000, 3, 4, 9, 13);
        cyc(pin, 1'b1, 1'b1);
        run_squares(3000, 6, 3, 4, 8);
        cyc(pin, 1'b0, 1'b0);
        cyc(pin, 1'b0, 1'b0);
        run_squares(4000, 12, 5, 3, 6);
        chk("R7 channel sum equals total", chan_sum(), {8'd0, total[CW-1:0]});

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end
endmodule